// File: doc/BRIEF.md
# Mixed access-type control and status register bank

This block is a small register bank for a peripheral. Every bit in it behaves according to a fixed access type. Some bits capture interrupt events from hardware inputs, either on a rising edge or on a falling edge. Others hold interrupt enables, hold control values that are loaded from a boot configuration just after reset, or fire one-cycle command strobes toward hardware.

Event status bits come in two kinds. The first kind is cleared when software reads it. The second kind is cleared only by writing ones into a clear mask. A single registered interrupt line combines every enabled status bit.

Software reaches the bank over a plain synchronous bus. A write lands on the clock edge where `we_i` is high. A read returns its data on `rdata_o` in the cycle after the edge where `re_i` is high, and `rdata_o` is zero in every other cycle.

Top module: `regbank_top`

Register map (byte addresses, word aligned):

| Address | Register | Software view |
|---|---|---|
| 0x00 | read-clear status | bits [3:0] read; a read clears them; writes are ignored |
| 0x04 | mask-clear status | bits [3:0] read; writing 1 to a bit clears it |
| 0x08 | interrupt enable | bits [7:0] read and write |
| 0x0C | control | bits [7:0] read and write; drives `ctrl_o` |
| 0x10 | strobe | bits [3:0] write only; reads as zero |

## Requirements
- R1: The polarity parameters select the event edge for each status bit; a 1 selects the rising edge and a 0 the falling edge. With the default values, read-clear status bits 0 and 1 set on a rising edge and bits 2 and 3 on a falling edge. Mask-clear status bits 0 and 2 set on a rising edge and bits 1 and 3 on a falling edge. An edge of the other direction does not set the bit.
- R2: A read of address 0x00 returns the read-clear status in bits [3:0] on `rdata_o` one cycle after the read edge. The same edge clears those status bits.
- R3: Reading address 0x04 does not change the mask-clear status. A write to 0x04 clears exactly the status bits whose write-data bit is 1.
- R4: If an event sets a status bit in the same cycle that a read or a mask write clears it, the bit stays set.
- R5: The interrupt enable register at 0x08 can be read and written. Bits [3:0] enable read-clear status bits [3:0], and bits [7:4] enable mask-clear status bits [3:0]. A status bit whose enable is 0 does not raise `irq_o`.
- R6: `irq_o` is the registered OR of all enabled status bits. It changes one cycle after the status or enable change that causes it.
- R7: On the first clock edge after reset is released, the control register at 0x0C loads `boot_cfg_i`. Later changes of `boot_cfg_i` have no effect. After that, software can read and write the register, and `ctrl_o` shows its value.
- R8: A write to 0x10 raises the `strb_o` bits whose write-data bit is 1 for exactly the one cycle after the write edge. Reading 0x10 returns zero.
- R9: A read of an unmapped address, or of any address whose bits [1:0] are not zero, returns zero. Writes to those addresses, and writes to 0x00, change nothing.
- R10: While reset is active, `rdata_o`, `ctrl_o`, `strb_o` and `irq_o` are all zero.
- R11: Each event input passes through a two-flop synchronizer and then an edge detector. An input change made before clock edge k sets its status bit at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Byte address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read enable |
| rdata_o | output | 32 | Read data, valid one cycle after the read edge |
| ev_rc_i | input | N_RC | Event inputs for the read-clear status bits |
| ev_mc_i | input | N_MC | Event inputs for the mask-clear status bits |
| boot_cfg_i | input | N_CTRL | Value loaded into the control register after reset |
| ctrl_o | output | N_CTRL | Control register value |
| strb_o | output | N_STRB | One-cycle command strobes |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check the following on every cycle:
- an edge pulse never lasts two cycles;
- an event always leaves its status bit set;
- a status bit drops only when a clear is applied;
- every interrupt, strobe bit and unmapped read result can be traced back to its cause;
- the boot capture matches the configuration input.

Only the bench scenarios can show the rest. These are the exact latency from an input change to the status bit and then to `irq_o`, the choice of edge direction for each bit, the event-wins case under both kinds of clear, and the fact that ignored accesses leave the register contents unchanged.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT_RC,
    SEL_STAT_MC,
    SEL_IEN,
    SEL_CTRL,
    SEL_STRB
  } reg_sel_e;

  // word indices (byte address >> 2)
  localparam int unsigned WIDX_STAT_RC = 0;
  localparam int unsigned WIDX_STAT_MC = 1;
  localparam int unsigned WIDX_IEN     = 2;
  localparam int unsigned WIDX_CTRL    = 3;
  localparam int unsigned WIDX_STRB    = 4;
endpackage

// File: rtl/regbank_edge.sv
module regbank_edge #(
  parameter int unsigned   N    = 4,
  parameter logic [N-1:0]  RISE = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  output logic [N-1:0] pulse_o
);
  logic [N-1:0] sync1_q, sync2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= ev_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (RISE[i]) begin : g_rise
      assign pulse_o[i] = sync2_q[i] & ~prev_q[i];
    end else begin : g_fall
      assign pulse_o[i] = ~sync2_q[i] & prev_q[i];
    end

    // R1: an edge yields a single-cycle pulse
    p_pulse_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_o[i] |=> !pulse_o[i]);
  end
endmodule

// File: rtl/regbank_status.sv
module regbank_status #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] stat_q;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= set_i | (stat_q & ~clr_i);
  end

  assign stat_o = stat_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> stat_q[i]);
    p_hold_no_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_q[i] && !clr_i[i]) |=> stat_q[i]);
  end
endmodule

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic [AW-1:0] addr_i,
  output reg_sel_e      sel_o
);
  localparam int unsigned IW = AW - 2;

  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i[1:0] == 2'b00) begin
      case (addr_i[AW-1:2])
        IW'(WIDX_STAT_RC): sel_o = SEL_STAT_RC;
        IW'(WIDX_STAT_MC): sel_o = SEL_STAT_MC;
        IW'(WIDX_IEN):     sel_o = SEL_IEN;
        IW'(WIDX_CTRL):    sel_o = SEL_CTRL;
        IW'(WIDX_STRB):    sel_o = SEL_STRB;
        default:           sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
#(
  parameter int unsigned       AW      = 8,
  parameter int unsigned       N_RC    = 4,
  parameter int unsigned       N_MC    = 4,
  parameter int unsigned       N_CTRL  = 8,
  parameter int unsigned       N_STRB  = 4,
  parameter logic [N_RC-1:0]   RC_RISE = 4'b0011,
  parameter logic [N_MC-1:0]   MC_RISE = 4'b0101
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_RC-1:0]   ev_rc_i,
  input  logic [N_MC-1:0]   ev_mc_i,
  input  logic [N_CTRL-1:0] boot_cfg_i,
  output logic [N_CTRL-1:0] ctrl_o,
  output logic [N_STRB-1:0] strb_o,
  output logic              irq_o
);
  localparam int unsigned N_IRQ = N_RC + N_MC;

  reg_sel_e          sel;
  logic [N_RC-1:0]   rc_pulse, rc_clr, stat_rc;
  logic [N_MC-1:0]   mc_pulse, mc_clr, stat_mc;
  logic [N_IRQ-1:0]  ien_q;
  logic [N_CTRL-1:0] ctrl_q;
  logic              loaded_q;
  logic [N_STRB-1:0] strb_q;
  logic              irq_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic              wr_ien, wr_ctrl, wr_strb, wr_mc, rd_rc;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;

  regbank_decode #(.AW(AW)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  assign wr_ien  = we_i && (sel == SEL_IEN);
  assign wr_ctrl = we_i && (sel == SEL_CTRL);
  assign wr_strb = we_i && (sel == SEL_STRB);
  assign wr_mc   = we_i && (sel == SEL_STAT_MC);
  assign rd_rc   = re_i && (sel == SEL_STAT_RC);

  regbank_edge #(.N(N_RC), .RISE(RC_RISE)) u_edge_rc (
    .clk_i (clk_i), .rst_ni (rst_ni), .ev_i (ev_rc_i), .pulse_o (rc_pulse)
  );
  regbank_edge #(.N(N_MC), .RISE(MC_RISE)) u_edge_mc (
    .clk_i (clk_i), .rst_ni (rst_ni), .ev_i (ev_mc_i), .pulse_o (mc_pulse)
  );

  assign rc_clr = {N_RC{rd_rc}};
  assign mc_clr = wr_mc ? wdata_i[N_MC-1:0] : '0;

  regbank_status #(.N(N_RC)) u_stat_rc (
    .clk_i (clk_i), .rst_ni (rst_ni), .set_i (rc_pulse), .clr_i (rc_clr), .stat_o (stat_rc)
  );
  regbank_status #(.N(N_MC)) u_stat_mc (
    .clk_i (clk_i), .rst_ni (rst_ni), .set_i (mc_pulse), .clr_i (mc_clr), .stat_o (stat_mc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q    <= '0;
      ctrl_q   <= '0;
      loaded_q <= 1'b0;
      strb_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_ien) ien_q <= wdata_i[N_IRQ-1:0];
      // boot capture takes the first cycle after reset
      if (!loaded_q) begin
        ctrl_q   <= boot_cfg_i;
        loaded_q <= 1'b1;
      end else if (wr_ctrl) begin
        ctrl_q <= wdata_i[N_CTRL-1:0];
      end
      strb_q <= wr_strb ? wdata_i[N_STRB-1:0] : '0;
      irq_q  <= |({stat_mc, stat_rc} & ien_q);
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_STAT_RC: rd_mux = DATA_W'(stat_rc);
      SEL_STAT_MC: rd_mux = DATA_W'(stat_mc);
      SEL_IEN:     rd_mux = DATA_W'(ien_q);
      SEL_CTRL:    rd_mux = DATA_W'(ctrl_q);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= re_i ? rd_mux : '0;
  end

  assign rdata_o = rdata_q;
  assign ctrl_o  = ctrl_q;
  assign strb_o  = strb_q;
  assign irq_o   = irq_q;

  p_irq_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(|({stat_mc, stat_rc} & ien_q)));

  p_boot_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loaded_q) |-> (ctrl_o == $past(boot_cfg_i)));

  p_unmapped_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && sel == SEL_NONE) |=> (rdata_o == '0));

  for (genvar i = 0; i < N_STRB; i++) begin : g_strb_chk
    p_strobe_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      strb_o[i] |-> $past(wr_strb && wdata_i[i]));
  end
endmodule

// File: tb/tb_regbank_top.sv
`timescale 1ns/1ps
module tb_regbank_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        re_i = 1'b0;
  logic [31:0] rdata_o;
  logic [3:0]  ev_rc_i = '0;
  logic [3:0]  ev_mc_i = '0;
  logic [7:0]  boot_cfg_i = 8'hA5;
  logic [7:0]  ctrl_o;
  logic [3:0]  strb_o;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic re_d = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk_i = ~clk_i;

  regbank_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
    .re_i(re_i), .rdata_o(rdata_o), .ev_rc_i(ev_rc_i), .ev_mc_i(ev_mc_i),
    .boot_cfg_i(boot_cfg_i), .ctrl_o(ctrl_o), .strb_o(strb_o), .irq_o(irq_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compare read data with scoreboard
  always @(posedge clk_i) re_d <= re_i;
  always @(negedge clk_i) begin
    if (re_d) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 32'h1, 32'h0);
      else chk(tag_q.pop_front(), rdata_o, exp_q.pop_front());
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(posedge clk_i);
    #1 we_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
    @(negedge clk_i);
    addr_i = a; re_i = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(posedge clk_i);
    #1 re_i = 1'b0;
  endtask

  task automatic set_rc(logic [3:0] v);
    @(negedge clk_i);
    ev_rc_i = v;
  endtask

  task automatic set_mc(logic [3:0] v);
    @(negedge clk_i);
    ev_mc_i = v;
  endtask

  task automatic settle();
    repeat (5) @(posedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10 rdata", rdata_o, 0);
    chk("R10 ctrl", 32'(ctrl_o), 0);
    chk("R10 strb", 32'(strb_o), 0);
    chk("R10 irq", 32'(irq_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R7 boot capture", 32'(ctrl_o), 32'hA5);
    boot_cfg_i = 8'h3C;
    settle();
    @(negedge clk_i);
    chk("R7 boot latched once", 32'(ctrl_o), 32'hA5);
    wr(8'h0C, 32'h5A);
    @(negedge clk_i);
    chk("R7 ctrl write", 32'(ctrl_o), 32'h5A);
    rd(8'h0C, 32'h5A, "R7 ctrl readback");

    // R1 R2: rising bit0 sets, falling-polarity bit2 does not
    set_rc(4'b0101);
    settle();
    rd(8'h00, 32'h1, "R1 rc rise");
    rd(8'h00, 32'h0, "R2 cleared by read");
    set_rc(4'b0000);
    settle();
    rd(8'h00, 32'h4, "R1 rc fall");
    // R11 R4: input change before edge k, reads at k+1..k+4
    set_rc(4'b0010);
    rd(8'h00, 32'h0, "R11 not yet set");
    rd(8'h00, 32'h0, "R4 set with read clear");
    rd(8'h00, 32'h2, "R4 event won");
    rd(8'h00, 32'h0, "R2 cleared");
    set_rc(4'b1010);
    settle();
    rd(8'h00, 32'h0, "R1 rise ignored on fall bit");
    set_rc(4'b0010);
    settle();
    rd(8'h00, 32'h8, "R1 fall bit3");
    set_rc(4'b0000);
    settle();
    rd(8'h00, 32'h0, "R1 fall ignored on rise bit");

    // R3 mask-clear status
    set_mc(4'b0011);
    settle();
    rd(8'h04, 32'h1, "R1 mc rise");
    set_mc(4'b0001);
    settle();
    rd(8'h04, 32'h3, "R1 mc fall");
    rd(8'h04, 32'h3, "R3 read no clear");
    wr(8'h04, 32'h1);
    rd(8'h04, 32'h2, "R3 mask clear");
    set_mc(4'b0101);
    @(negedge clk_i);
    wr(8'h04, 32'h6);
    rd(8'h04, 32'h4, "R4 mc event wins");
    wr(8'h04, 32'h4);
    rd(8'h04, 32'h0, "R3 mask clear bit2");

    // R5 R6 enables and interrupt timing
    wr(8'h08, 32'h01);
    rd(8'h08, 32'h01, "R5 ien readback");
    set_rc(4'b0001);
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R11 irq k+1", 32'(irq_o), 0);
    @(negedge clk_i);
    chk("R6 irq registered", 32'(irq_o), 0);
    @(negedge clk_i);
    chk("R6 irq set", 32'(irq_o), 1);
    wr(8'h08, 32'h00);
    @(negedge clk_i);
    chk("R6 irq one cycle late", 32'(irq_o), 1);
    @(negedge clk_i);
    chk("R5 irq gated", 32'(irq_o), 0);
    wr(8'h08, 32'h10);
    set_mc(4'b0100);
    settle();
    @(negedge clk_i);
    chk("R1 mc wrong edge no irq", 32'(irq_o), 0);
    set_mc(4'b0101);
    settle();
    @(negedge clk_i);
    chk("R5 mc irq", 32'(irq_o), 1);
    wr(8'h04, 32'h1);
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R6 irq drop", 32'(irq_o), 0);

    // R9 unmapped and ignored
    rd(8'h14, 32'h0, "R9 unmapped read");
    rd(8'h0E, 32'h0, "R9 unaligned read");
    wr(8'h0E, 32'hFF);
    wr(8'h00, 32'hF);
    rd(8'h0C, 32'h5A, "R9 unaligned write ignored");
    rd(8'h00, 32'h1, "R9 rc write ignored");
    rd(8'h00, 32'h0, "R2 clear after read");

    // R8 strobes
    @(negedge clk_i);
    chk("R8 strobe idle", 32'(strb_o), 0);
    wr(8'h10, 32'h5);
    @(negedge clk_i);
    chk("R8 strobe pulse", 32'(strb_o), 32'h5);
    @(negedge clk_i);
    chk("R8 strobe width", 32'(strb_o), 0);
    rd(8'h10, 32'h0, "R8 strobe reads zero");

    repeat (3) @(negedge clk_i);
    chk("scoreboard drained", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule